// File: doc/BRIEF.md
# Four-Trit Ternary Ripple Adder

This block adds two unsigned four-trit ternary numbers with no clock. Each trit travels on two wires; the block returns a four-trit sum and a carry-out trit. The lowest position is a half adder with no carry input. Each of the upper positions is a reduced full adder. Its carry input can only be 0 or 1, because two trits plus a carry of at most 1 never reach a carry of 2.

Every cell works in a decoded-operand multiplexer style. The A trit is turned into one-hot flags. The B trit picks which flag drives each "sum digit is 1", "sum digit is 2" and "carry is 1" line. Small encoders then turn those lines back into trit codes. The reduced full adder needs only three sum flags across both carry-in cases, because the flags for the two cases overlap. An error output marks any operand trit that holds the illegal code.

Top module: `tern_ripple_adder`

## Requirements
- R1: With legal operands, value(sum_o) + 81·value(cout_o) equals value(a_i) + value(b_i), where value() is the base-3 weight sum of the trits.
- R2: Trit i lives in bits [2i+1:2i]. The code 2'b00 means 0, 2'b01 means 1 and 2'b10 means 2. 2'b11 is illegal. With legal operands, no sum trit is ever 2'b11.
- R3: cout_o is always 2'b00 or 2'b01, so the largest result is 160 (operands 2222 + 2222 give sum 2221 with carry 1).
- R4: The carry out of every stage is 0 or 1; a carry of 2 never occurs inside the chain.
- R5: err_o is 1 exactly when at least one operand trit of a_i or b_i holds 2'b11.
- R6: Sum trit 0 equals (a0 + b0) mod 3 and does not depend on any higher operand trit.
- R7: A carry ripples through every position: 2222 + 0001 gives sum 0000 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A, four trits, least significant trit in bits [1:0] |
| b_i | input | 8 | Operand B, same layout as a_i |
| sum_o | output | 8 | Four-trit sum, same layout |
| cout_o | output | 2 | Carry-out trit of the top position |
| err_o | output | 1 | High when any operand trit holds the illegal code |

## Verification
The bench applies every one of the 6561 legal operand pairs and compares each result with integer arithmetic. An error in the half adder's flag selection would corrupt sum trit 0 for some B values. A mix-up between the carry-in-0 and carry-in-1 flag sets would show up only on pairs where a carry arrives, which is exactly the case the full sweep covers. The long-ripple case 2222 + 0001 and the maximum 2222 + 2222 are also checked on their own, because a stage that drops its carry input fails both. Illegal codes are placed in every trit position of each operand in turn to catch an error flag that misses a position.

// File: rtl/tern_add_pkg.sv
package tern_add_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T0 = 2'b00;
  localparam trit_t T1 = 2'b01;
  localparam trit_t T2 = 2'b10;

  // three-way flag multiplexer, illegal select yields 0
  function automatic logic mux3(trit_t sel, logic d0, logic d1, logic d2);
    case (sel)
      T0:      return d0;
      T1:      return d1;
      T2:      return d2;
      default: return 1'b0;
    endcase
  endfunction

  // two-flag encoder: digit-2 flag wins over digit-1 flag
  function automatic trit_t enc2(logic f1, logic f2);
    return f2 ? T2 : (f1 ? T1 : T0);
  endfunction

  // one-flag encoder: carry is 1 or 0
  function automatic trit_t enc1(logic f);
    return f ? T1 : T0;
  endfunction
endpackage

// File: rtl/tern_decode.sv
module tern_decode
  import tern_add_pkg::*;
(
  input  trit_t t_i,
  output logic  is0_o,
  output logic  is1_o,
  output logic  is2_o
);
  logic lo, notmax, mid_n;

  assign lo     = (t_i == T0);        // low-threshold inverter
  assign notmax = (t_i != T2);        // high-threshold inverter
  assign mid_n  = ~(notmax & ~lo);    // NAND of the two, low for digit 1

  assign is0_o = lo;
  assign is1_o = ~mid_n;
  assign is2_o = ~notmax;
endmodule

// File: rtl/tern_half_cell.sv
module tern_half_cell
  import tern_add_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  output trit_t s_o,
  output trit_t c_o
);
  logic is0, is1, is2;
  logic f1, f2, cm;

  tern_decode i_dec (.t_i(a_i), .is0_o(is0), .is1_o(is1), .is2_o(is2));

  assign f1 = mux3(b_i, is1, is0, is2);   // sum digit is 1
  assign f2 = mux3(b_i, is2, is1, is0);   // sum digit is 2
  assign cm = mux3(b_i, 1'b0, is2, ~is0); // carry is 1

  assign s_o = enc2(f1, f2);
  assign c_o = enc1(cm);
endmodule

// File: rtl/tern_rfa_cell.sv
module tern_rfa_cell
  import tern_add_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t cin_i,
  output trit_t s_o,
  output trit_t c_o
);
  logic is0, is1, is2;
  logic f1, f2, f3, cm0, cm1;
  trit_t s_c0, s_c1;

  tern_decode i_dec (.t_i(a_i), .is0_o(is0), .is1_o(is1), .is2_o(is2));

  // shared flags: digit-2 for cin=1 reuses digit-1 for cin=0
  assign f1  = mux3(b_i, is1, is0, is2);
  assign f2  = mux3(b_i, is2, is1, is0);
  assign f3  = mux3(b_i, is0, is2, is1);
  assign cm0 = mux3(b_i, 1'b0, is2, ~is0);
  assign cm1 = mux3(b_i, is2, ~is0, 1'b1);

  assign s_c0 = enc2(f1, f2);
  assign s_c1 = enc2(f3, f1);

  always_comb begin
    case (cin_i)
      T1:      begin s_o = s_c1; c_o = enc1(cm1); end
      default: begin s_o = s_c0; c_o = enc1(cm0); end
    endcase
  end
endmodule

// File: rtl/tern_ripple_adder.sv
module tern_ripple_adder
  import tern_add_pkg::*;
#(
  parameter int NUM_TRITS = 4
) (
  input  logic [2*NUM_TRITS-1:0] a_i,
  input  logic [2*NUM_TRITS-1:0] b_i,
  output logic [2*NUM_TRITS-1:0] sum_o,
  output logic [1:0]             cout_o,
  output logic                   err_o
);
  localparam int W = 2 * NUM_TRITS;

  logic [W-1:0] carry;  // carry out of each stage

  generate
    for (genvar i = 0; i < NUM_TRITS; i++) begin : g_stage
      if (i == 0) begin : g_half
        tern_half_cell i_cell (
          .a_i(a_i[1:0]), .b_i(b_i[1:0]),
          .s_o(sum_o[1:0]), .c_o(carry[1:0])
        );
      end else begin : g_full
        tern_rfa_cell i_cell (
          .a_i(a_i[2*i+1:2*i]), .b_i(b_i[2*i+1:2*i]),
          .cin_i(carry[2*i-1:2*i-2]),
          .s_o(sum_o[2*i+1:2*i]), .c_o(carry[2*i+1:2*i])
        );
      end
    end
  endgenerate

  assign cout_o = carry[W-1:W-2];

  always_comb begin
    err_o = 1'b0;
    for (int i = 0; i < NUM_TRITS; i++)
      err_o = err_o | (&a_i[2*i+:2]) | (&b_i[2*i+:2]);
  end
endmodule

// File: rtl/tern_ripple_adder_chk.sv
module tern_ripple_adder_chk #(
  parameter int NUM_TRITS = 4
) (
  input logic [2*NUM_TRITS-1:0] a_i,
  input logic [2*NUM_TRITS-1:0] b_i,
  input logic [2*NUM_TRITS-1:0] sum_o,
  input logic [1:0]             cout_o,
  input logic                   err_o,
  input logic [2*NUM_TRITS-1:0] carry_i
);
  function automatic int tval(logic [2*NUM_TRITS-1:0] v);
    int r = 0;
    for (int i = NUM_TRITS - 1; i >= 0; i--) r = r * 3 + int'(v[2*i+:2]);
    return r;
  endfunction

  function automatic logic legal(logic [2*NUM_TRITS-1:0] v);
    for (int i = 0; i < NUM_TRITS; i++) if (&v[2*i+:2]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int pow3();
    int r = 1;
    for (int i = 0; i < NUM_TRITS; i++) r = r * 3;
    return r;
  endfunction

  always_comb begin
    if (!$isunknown({a_i, b_i, sum_o, cout_o, err_o, carry_i})) begin
      assert_cout_range_R3: assert (cout_o == 2'b00 || cout_o == 2'b01)
        else $error("cout out of range");
      for (int k = 0; k < NUM_TRITS; k++)
        assert_stage_carry_R4: assert (carry_i[2*k+1] == 1'b0)
          else $error("stage carry of 2");
      assert_err_flag_R5: assert (err_o == !(legal(a_i) && legal(b_i)))
        else $error("error flag mismatch");
      if (legal(a_i) && legal(b_i)) begin
        assert_sum_value_R1: assert (tval(sum_o) + pow3() * int'(cout_o) == tval(a_i) + tval(b_i))
          else $error("sum value wrong");
        assert_sum_codes_R2: assert (legal(sum_o))
          else $error("illegal sum code");
      end
    end
  end
endmodule

bind tern_ripple_adder tern_ripple_adder_chk #(.NUM_TRITS(NUM_TRITS)) i_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .cout_o(cout_o), .err_o(err_o), .carry_i(carry)
);

// File: tb/test_tern_ripple_adder.sv
module test_tern_ripple_adder;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic [1:0] cout;
  logic err;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tern_ripple_adder #(.NUM_TRITS(N)) i_tern_ripple_adder (
    .a_i(a), .b_i(b), .sum_o(sum), .cout_o(cout), .err_o(err)
  );

  function automatic logic [W-1:0] enc(int v);
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) begin r[2*i+:2] = 2'(v % 3); v = v / 3; end
    return r;
  endfunction

  task automatic apply(logic [W-1:0] av, logic [W-1:0] bv);
    @(posedge clk);
    a = av; b = bv;
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [W+2:0] act, logic [W+2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h)", req, act, exp, a, b);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    a = '0; b = '0;
    @(negedge clk);
    chk("R1 zero", {sum, cout, err}, {enc(0), 2'b00, 1'b0});

    // R1 R2 R3 R4: full sweep of legal operand pairs
    for (int x = 0; x < 81; x++)
      for (int y = 0; y < 81; y++) begin
        apply(enc(x), enc(y));
        chk("R1/R2/R3/R4 sweep", {sum, cout, err}, {enc((x + y) % 81), 2'((x + y) / 81), 1'b0});
      end

    // R6: trit 0 independent of upper trits
    for (int x = 0; x < 3; x++)
      for (int y = 0; y < 3; y++) begin
        apply(enc(x + 3 * 26), enc(y + 3 * 13));
        chk("R6 low trit", {1'b0, sum[1:0]}, {1'b0, 2'((x + y) % 3)});
      end

    // R7: long ripple
    apply(enc(80), enc(1));
    chk("R7 ripple", {sum, cout, err}, {enc(0), 2'b01, 1'b0});
    apply(enc(1), enc(80));
    chk("R7 ripple swap", {sum, cout, err}, {enc(0), 2'b01, 1'b0});

    // R3: maximum result 160 -> 2221 carry 1
    apply(enc(80), enc(80));
    chk("R3 max", {sum, cout, err}, {enc(79), 2'b01, 1'b0});

    // R5: illegal code in each position of each operand
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] bad;
      bad = enc(40);
      bad[2*i+:2] = 2'b11;
      apply(bad, enc(5));
      chk("R5 err on a", {2'b00, err}, 3'b001);
      apply(enc(7), bad);
      chk("R5 err on b", {2'b00, err}, 3'b001);
    end
    apply(enc(80), enc(80));
    chk("R5 err clear", {2'b00, err}, 3'b000);

    done = 1;
    report();
  end
endmodule